// File: doc/BRIEF.md
# Three-wire configuration register interface

This block is the programming port of a frequency-synthesizer front end. A host shifts 16-bit words in over a three-wire serial link: a serial clock, a data line, and an active-low frame strobe. The two low bits of each word pick one of four configuration registers, and the other fourteen bits are stored there when the frame closes. The registers feed the synthesizer logic with several fields: a 28-bit fractional divide word, an 8-bit integer divide value, a reference divide select, charge-pump current and bleed codes, a charge-pump doubling bit, a sigma-delta bypass bit, a test code and a reset-delay code.

The block also builds the circuit enables. Each enable is a hardware pin ANDed with a software bit. There are two separate shutdown paths. The active-low shutdown pin drops everything. The software power bit drops every circuit but leaves the serial port and the registers running, so the device can still be programmed. All three serial lines are sampled by the core clock through a two-stage synchroniser. Every register update therefore happens in the core clock domain.

Top module: `cfg3w_ctrl`

## Requirements
- R1: While the frame strobe is low, each rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. A rising edge of the frame strobe commits the shifted word.
- R2: Word bits [1:0] select the target register: 00 upper fraction, 01 lower fraction, 10 divider settings, 11 control settings. Bits [15:2] are stored in that register, and the other three registers keep their values.
- R3: Divider word layout: [15:14] reference divide select, [13:12] charge-pump bleed, [11:10] charge-pump current, [9:2] integer divide value.
- R4: Control word layout: [15:14] reset delay, [13:8] test code, [7] sigma-delta bypass, [6] software power (1 = on), [5] modulator software enable, [4] LO-buffer software enable, [3] spare bit, [2] charge-pump double.
- R5: The fractional output is the upper-fraction register (bits 27:14) joined with the lower-fraction register (bits 13:0).
- R6: Synchronous reset sets the registers to these values: fraction upper 8192 and lower 0; reference select 0, bleed 0, current 3, integer value 177; reset delay 0, test 0, bypass 0, power 0, modulator enable 1, buffer enable 1, spare 1, double 1.
- R7: The modulator enable is high only when the shutdown pin is high, the power bit is 1, the modulator pin is high and the modulator bit is 1. The LO-buffer enable is formed the same way from the buffer pin and the buffer bit.
- R8: The synthesizer enable is high only when the shutdown pin is high, the power bit is 1 and the synthesizer pin is high.
- R9: The core-on output equals the shutdown pin ANDed with the power bit. When it is low, all circuit enables are low, whatever the other pins are.
- R10: Serial clock edges and data that arrive while the frame strobe is high leave the shift register and all registers unchanged.
- R11: If a frame carries more than 16 clocks, only the last 16 bits shifted in are committed.
- R12: A commit becomes visible on the outputs on the fourth core clock edge after the frame strobe rises, and not earlier. The enables follow the pins combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_frame_n | input | 1 | Frame strobe, low while shifting; rising edge commits |
| pin_shdn_n | input | 1 | Hardware shutdown, active low |
| pin_tx_en | input | 1 | Hardware modulator enable |
| pin_syn_en | input | 1 | Hardware synthesizer enable |
| pin_buf_en | input | 1 | Hardware LO-buffer enable |
| frac_word | output | 28 | Fractional divide word |
| int_div | output | 8 | Integer divide value |
| ref_div_sel | output | 2 | Reference divide select |
| cp_bleed | output | 2 | Charge-pump bleed code |
| cp_current | output | 2 | Charge-pump current code |
| cp_double | output | 1 | Charge-pump current doubling |
| sd_bypass | output | 1 | Sigma-delta bypass (integer mode) |
| test_code | output | 6 | Test mode code |
| reset_delay | output | 2 | Reset delay code |
| ctrl_spare | output | 1 | Spare control bit as stored |
| core_on | output | 1 | Global power enable |
| mod_on | output | 1 | Modulator enable |
| synth_on | output | 1 | Synthesizer enable |
| lobuf_on | output | 1 | LO-buffer enable |

## Verification
A register output changes on the fourth core edge after the frame strobe rises: two synchroniser stages, one edge-detect strobe register, then the register itself. After each frame the bench waits ten core cycles before it compares the outputs. One directed case samples the same output three and four edges after the strobe rises, to pin down that latency exactly. The enables are combinational from the pins, so the bench changes the pins at a falling edge and checks the enables one nanosecond later.

// File: rtl/cfg3w_pkg.sv
// Package: shared widths, register selectors, field layouts and reset values
// for the three-wire configuration interface.
package cfg3w_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int FIELD_W = WORD_W - ADDR_W;
    localparam int NUM_REG = 1 << ADDR_W;
    localparam int FRAC_W  = 2 * FIELD_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_FRAC_HI = 2'b00,
        SEL_FRAC_LO = 2'b01,
        SEL_DIV     = 2'b10,
        SEL_CTRL    = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] ref_sel;
        logic [1:0] bleed;
        logic [1:0] cp_cur;
        logic [7:0] ndiv;
    } div_fields_t;

    typedef struct packed {
        logic [1:0] rdly;
        logic [5:0] test;
        logic       sd_byp;
        logic       pwr_on;
        logic       tx_on;
        logic       buf_on;
        logic       spare;
        logic       cp_dbl;
    } ctrl_fields_t;

    localparam logic [FIELD_W-1:0] DEF_FRAC_HI = 14'd8192;
    localparam logic [FIELD_W-1:0] DEF_FRAC_LO = 14'd0;
    localparam logic [FIELD_W-1:0] DEF_DIV     = {2'b00, 2'b00, 2'b11, 8'd177};
    localparam logic [FIELD_W-1:0] DEF_CTRL    = {2'b00, 6'd0, 6'b001111};

    // Reset value of register slot idx.
    function automatic logic [FIELD_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return DEF_FRAC_HI;
            1:       return DEF_FRAC_LO;
            2:       return DEF_DIV;
            default: return DEF_CTRL;
        endcase
    endfunction
endpackage

// File: rtl/cfg3w_sync.sv
// Module: multi-bit, multi-stage synchroniser into the core clock.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module cfg3w_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop: capture the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Later flops: let metastability resolve.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
// Module: serial word receiver. Detects serial clock and frame strobe edges
// on synchronised inputs, shifts MSB first while the strobe is low and emits
// a one-cycle write strobe with the word after the strobe rises.
// Assumes serial phases last at least two core cycles.
module cfg3w_shift
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              sen_s,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_word
);
    logic              sck_d;
    logic              sen_d;
    logic [WORD_W-1:0] shreg;
    logic              sck_rise;
    logic              sen_rise;

    assign sck_rise = sck_s & ~sck_d;
    assign sen_rise = sen_s & ~sen_d;

    // Edge history of the synchronised lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            sen_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            sen_d <= sen_s;
        end
    end

    // Shift register: takes a bit per serial clock rise inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 shreg <= '0;
        else if (sck_rise && !sen_s) shreg <= {shreg[WORD_W-2:0], sdi_s};
    end

    // Commit strobe and word, one cycle after the strobe rise is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_word <= '0;
        end else begin
            wr_stb  <= sen_rise;
            if (sen_rise) wr_word <= shreg;
        end
    end

    a_r10_hold_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> $stable(shreg));
    a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/cfg3w_regs.sv
// Module: four-slot configuration register bank with per-slot reset values.
// Assumes wr_word carries the slot address in its low bits.
module cfg3w_regs
    import cfg3w_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_stb,
    input  logic [WORD_W-1:0]                wr_word,
    output logic [NUM_REG-1:0][FIELD_W-1:0]  regs_q
);
    logic [ADDR_W-1:0]  wr_addr;
    logic [FIELD_W-1:0] wr_data;

    assign wr_addr = wr_word[ADDR_W-1:0];
    assign wr_data = wr_word[WORD_W-1:ADDR_W];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_slot
        localparam logic [ADDR_W-1:0]  MY_ADDR = ADDR_W'(g);
        localparam logic [FIELD_W-1:0] MY_DEF  = reg_default(g);

        // Slot storage: load on a commit addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                            regs_q[g] <= MY_DEF;
            else if (wr_stb && wr_addr == MY_ADDR) regs_q[g] <= wr_data;
        end

        a_r2_change_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(regs_q[g]) |-> ($past(wr_stb) && $past(wr_word[ADDR_W-1:0]) == MY_ADDR));
    end
endmodule

// File: rtl/cfg3w_pwr.sv
// Module: enable gating. Each circuit enable is a pin ANDed with a software
// bit, under the global shutdown pin and software power bit.
// Assumes pins are static levels; outputs are combinational.
module cfg3w_pwr (
    input  logic pin_shdn_n,
    input  logic pin_tx_en,
    input  logic pin_syn_en,
    input  logic pin_buf_en,
    input  logic sw_pwr_on,
    input  logic sw_tx_on,
    input  logic sw_buf_on,
    output logic core_on,
    output logic mod_on,
    output logic synth_on,
    output logic lobuf_on
);
    // Enable combination for each block.
    always_comb begin
        core_on  = pin_shdn_n & sw_pwr_on;
        mod_on   = core_on & pin_tx_en & sw_tx_on;
        synth_on = core_on & pin_syn_en;
        lobuf_on = core_on & pin_buf_en & sw_buf_on;
    end
endmodule

// File: rtl/cfg3w_ctrl.sv
// Module: top of the three-wire configuration interface. Synchronises the
// serial lines, receives words, stores them in four registers and drives the
// configuration fields and circuit enables.
// Assumes a core clock at least four times the serial clock rate.
module cfg3w_ctrl
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_frame_n,
    input  logic              pin_shdn_n,
    input  logic              pin_tx_en,
    input  logic              pin_syn_en,
    input  logic              pin_buf_en,
    output logic [FRAC_W-1:0] frac_word,
    output logic [7:0]        int_div,
    output logic [1:0]        ref_div_sel,
    output logic [1:0]        cp_bleed,
    output logic [1:0]        cp_current,
    output logic              cp_double,
    output logic              sd_bypass,
    output logic [5:0]        test_code,
    output logic [1:0]        reset_delay,
    output logic              ctrl_spare,
    output logic              core_on,
    output logic              mod_on,
    output logic              synth_on,
    output logic              lobuf_on
);
    logic [2:0]                        ser_s;
    logic                              wr_stb;
    logic [WORD_W-1:0]                 wr_word;
    logic [NUM_REG-1:0][FIELD_W-1:0]   regs_q;
    div_fields_t                       div_f;
    ctrl_fields_t                      ctl_f;

    cfg3w_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_frame_n, ser_data, ser_clk}),
        .q     (ser_s)
    );

    cfg3w_shift i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (ser_s[0]),
        .sdi_s   (ser_s[1]),
        .sen_s   (ser_s[2]),
        .wr_stb  (wr_stb),
        .wr_word (wr_word)
    );

    cfg3w_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_word (wr_word),
        .regs_q  (regs_q)
    );

    assign div_f = div_fields_t'(regs_q[SEL_DIV]);
    assign ctl_f = ctrl_fields_t'(regs_q[SEL_CTRL]);

    // Field fan-out to the synthesizer logic.
    always_comb begin
        frac_word   = {regs_q[SEL_FRAC_HI], regs_q[SEL_FRAC_LO]};
        int_div     = div_f.ndiv;
        ref_div_sel = div_f.ref_sel;
        cp_bleed    = div_f.bleed;
        cp_current  = div_f.cp_cur;
        cp_double   = ctl_f.cp_dbl;
        sd_bypass   = ctl_f.sd_byp;
        test_code   = ctl_f.test;
        reset_delay = ctl_f.rdly;
        ctrl_spare  = ctl_f.spare;
    end

    cfg3w_pwr i_pwr (
        .pin_shdn_n (pin_shdn_n),
        .pin_tx_en  (pin_tx_en),
        .pin_syn_en (pin_syn_en),
        .pin_buf_en (pin_buf_en),
        .sw_pwr_on  (ctl_f.pwr_on),
        .sw_tx_on   (ctl_f.tx_on),
        .sw_buf_on  (ctl_f.buf_on),
        .core_on    (core_on),
        .mod_on     (mod_on),
        .synth_on   (synth_on),
        .lobuf_on   (lobuf_on)
    );

    a_r7_mod_needs_pin_and_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mod_on |-> (pin_tx_en && ctl_f.tx_on));
    a_r7_buf_needs_pin_and_bit: assert property (@(posedge clk) disable iff (!rst_n)
        lobuf_on |-> (pin_buf_en && ctl_f.buf_on));
    a_r8_syn_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        synth_on |-> pin_syn_en);
    a_r9_shdn_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_shdn_n |-> !(mod_on || synth_on || lobuf_on || core_on));
    a_r9_pwr_bit_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_f.pwr_on |-> !(mod_on || synth_on || lobuf_on));
endmodule

// File: tb/test_cfg3w_ctrl.sv
`timescale 1ns/1ps
module test_cfg3w_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_frame_n = 1'b1;
    logic pin_shdn_n = 1'b1, pin_tx_en = 1'b1, pin_syn_en = 1'b1, pin_buf_en = 1'b1;
    logic [27:0] frac_word;
    logic [7:0]  int_div;
    logic [1:0]  ref_div_sel, cp_bleed, cp_current, reset_delay;
    logic        cp_double, sd_bypass, ctrl_spare;
    logic [5:0]  test_code;
    logic        core_on, mod_on, synth_on, lobuf_on;

    int n_chk = 0;
    int n_bad = 0;
    logic [13:0] mdl [4];

    always #2 clk = ~clk;

    cfg3w_ctrl i_cfg3w_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_frame_n(ser_frame_n), .pin_shdn_n(pin_shdn_n), .pin_tx_en(pin_tx_en),
        .pin_syn_en(pin_syn_en), .pin_buf_en(pin_buf_en), .frac_word(frac_word),
        .int_div(int_div), .ref_div_sel(ref_div_sel), .cp_bleed(cp_bleed),
        .cp_current(cp_current), .cp_double(cp_double), .sd_bypass(sd_bypass),
        .test_code(test_code), .reset_delay(reset_delay), .ctrl_spare(ctrl_spare),
        .core_on(core_on), .mod_on(mod_on), .synth_on(synth_on), .lobuf_on(lobuf_on)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected enables {core, mod, synth, buf} from pins and modelled control word.
    function automatic logic [3:0] exp_pwr();
        logic core;
        core = pin_shdn_n & mdl[3][4];
        return {core, core & pin_tx_en & mdl[3][3], core & pin_syn_en, core & pin_buf_en & mdl[3][2]};
    endfunction

    task automatic check_fields(input string tag);
        chk({tag, " R5 frac"},   32'(frac_word), 32'({mdl[0], mdl[1]}));
        chk({tag, " R3 ndiv"},   32'(int_div),     32'(mdl[2][7:0]));
        chk({tag, " R3 refsel"}, 32'(ref_div_sel), 32'(mdl[2][13:12]));
        chk({tag, " R3 bleed"},  32'(cp_bleed),    32'(mdl[2][11:10]));
        chk({tag, " R3 cpcur"},  32'(cp_current),  32'(mdl[2][9:8]));
        chk({tag, " R4 ctrl"},   32'({reset_delay, test_code, sd_bypass, ctrl_spare, cp_double}),
                                 32'({mdl[3][13:12], mdl[3][11:6], mdl[3][5], mdl[3][1], mdl[3][0]}));
    endtask

    task automatic check_pwr(input string tag);
        chk({tag, " R7 R8 R9 enables"}, 32'({core_on, mod_on, synth_on, lobuf_on}), 32'(exp_pwr()));
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        ser_frame_n = 1'b0;
        repeat (4) @(negedge clk);
        shift_bits(32'(w), 16);
        repeat (4) @(negedge clk);
        ser_frame_n = 1'b1;
        repeat (10) @(negedge clk);
        mdl[w[1:0]] = w[15:2];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd7741));
        mdl[0] = 14'd8192; mdl[1] = 14'd0;
        mdl[2] = {2'b00, 2'b00, 2'b11, 8'd177};
        mdl[3] = {2'b00, 6'd0, 6'b001111};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 reset values; R9 power bit 0 keeps everything off
        check_fields("R6 reset");
        check_pwr("R6 reset");

        // R4 R1 directed control word: power on, all enables
        send_word({2'b10, 6'h2A, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11});
        check_fields("R1 R4 ctrl");
        check_pwr("R7 ctrl");

        // R3 divider, R5 fraction halves
        send_word({2'b11, 2'b01, 2'b10, 8'd250, 2'b10});
        send_word({14'h3ABC, 2'b00});
        send_word({14'h1234, 2'b01});
        check_fields("R2 R3 R5 directed");

        // R7 R8 R9 full pin sweep with power bit on
        send_word({2'b00, 6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11});
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {pin_shdn_n, pin_tx_en, pin_syn_en, pin_buf_en} = 4'(p);
            #1;
            check_pwr("R7 R8 R9 sweep");
        end
        // R7 software bits cleared while pins high
        {pin_shdn_n, pin_tx_en, pin_syn_en, pin_buf_en} = 4'hF;
        send_word({2'b00, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11});
        check_pwr("R7 bits off");

        // R2 random frames with random pins
        for (int k = 0; k < 40; k++) begin
            w = 16'($urandom);
            send_word(w);
            {pin_shdn_n, pin_tx_en, pin_syn_en, pin_buf_en} = 4'($urandom);
            #1;
            check_fields("R2 random");
            check_pwr("R7 R8 random");
        end

        // R10 clocks while frame strobe high are ignored
        send_word({14'h0F0F, 2'b00});
        shift_bits(32'hFFFF_FFFF, 16);
        repeat (10) @(negedge clk);
        check_fields("R10 clocks outside frame");
        ser_frame_n = 1'b0;
        repeat (6) @(negedge clk);
        ser_frame_n = 1'b1;
        repeat (10) @(negedge clk);
        check_fields("R10 empty frame recommit");

        // R11 twenty clocks in one frame: last sixteen kept
        ser_frame_n = 1'b0;
        repeat (4) @(negedge clk);
        shift_bits({12'h0, 4'hD, 2'b11, 2'b00, 2'b01, 8'd99, 2'b10}, 20);
        repeat (4) @(negedge clk);
        ser_frame_n = 1'b1;
        repeat (10) @(negedge clk);
        mdl[2] = {2'b11, 2'b00, 2'b01, 8'd99};
        check_fields("R11 long frame");

        // R12 commit latency: old value after 3 edges, new after 4
        ser_frame_n = 1'b0;
        repeat (4) @(negedge clk);
        shift_bits(32'({2'b00, 2'b00, 2'b00, 8'd42, 2'b10}), 16);
        repeat (4) @(negedge clk);
        ser_frame_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 not yet visible", 32'(int_div), 32'd99);
        @(negedge clk);
        chk("R12 visible on fourth edge", 32'(int_div), 32'd42);
        mdl[2] = {2'b00, 2'b00, 2'b00, 8'd42};
        repeat (5) @(negedge clk);
        check_fields("R12 settled");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule